// File: doc/BRIEF.md
# Per-Target Priority Interrupt Selector

This block chooses, for every interrupt target, which pending source should be presented to that target. Each target sees the shared pending vector through its own enable mask. Among the sources that are both pending and enabled, the one with the highest 3-bit priority wins, and a tie goes to the smallest source number. The target's request line rises only when the winner's priority is strictly above that target's 3-bit threshold.

The winning source number and the request are both held in registers. The outputs therefore show the selection made from the inputs present at the previous rising clock edge. The source and target counts are parameters. Each target has its own selection tree and its own output registers, so one target's mask and threshold never affect another target.

Top module: `prio_irq_sel`

## Requirements
- R1: A source takes part in a target's selection only if its bit in `pend_i` is 1 and its bit `en_i[t*N_SRC+s]` is 1. A pending source that is disabled never wins, whatever its priority.
- R2: The reported ID for a target is the participating source with the largest priority, where the priority of source s is `prio_i[s*3 +: 3]`.
- R3: When several participating sources share the largest priority, the one with the smallest source number is reported.
- R4: `irq_o[t]` is 1 only when the winner's priority is strictly greater than `thresh_i[t*3 +: 3]`. A winner whose priority equals the threshold leaves the request at 0.
- R5: Both outputs are registered. They change only at a rising clock edge and reflect the inputs sampled at that edge.
- R6: The winner's ID is reported in `id_o[t*ID_W +: ID_W]` even when its priority does not exceed the threshold. A change of ID to a nonzero value with `irq_o[t]` low therefore means the winner was at or below the threshold.
- R7: When no source participates for a target, that target reports ID 0 and `irq_o[t]` is 0.
- R8: A winner of priority 0 never raises a request.
- R9: An active-low asynchronous reset clears every request and ID to 0 at once, without waiting for a clock edge.
- R10: Each target uses only its own enable mask and threshold, so targets with different masks can report different winners in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | N_SRC | Pending flag per source |
| en_i | input | N_TGT*N_SRC | Enable masks, target t at bits [t*N_SRC +: N_SRC] |
| prio_i | input | N_SRC*PRIO_W | Source priorities, source s at [s*PRIO_W +: PRIO_W] |
| thresh_i | input | N_TGT*PRIO_W | Target thresholds, target t at [t*PRIO_W +: PRIO_W] |
| irq_o | output | N_TGT | Registered request per target |
| id_o | output | N_TGT*ID_W | Registered winner ID, target t at [t*ID_W +: ID_W] |

## Verification
Both the request and the ID are due exactly one rising edge after the inputs that cause them. The bench drives inputs at the falling edge and reads the outputs at the next falling edge, so exactly one capturing edge lies between stimulus and check. A separate latency check reads the outputs shortly after new inputs are applied and before any edge, and expects the old values. The reset check samples the outputs mid-cycle right after reset is asserted, which shows that clearing does not wait for a clock.

// File: rtl/prio_sel_pkg.sv
package prio_sel_pkg;

    // Width of a priority or threshold field (levels 0..7)
    localparam int PRIO_W_DEF = 3;

    // Width needed to number n sources, at least one bit
    function automatic int id_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/prio_sel_tree.sv
// Tournament tree: finds the highest-priority participating source,
// lower source number preferred on a tie.
module prio_sel_tree #(
    parameter int N_SRC  = 8,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 3
) (
    input  logic [N_SRC-1:0]        part_i,
    input  logic [N_SRC*PRIO_W-1:0] prio_i,
    output logic                    win_vld_o,
    output logic [PRIO_W-1:0]       win_prio_o,
    output logic [ID_W-1:0]         win_id_o
);

    localparam int LVL    = (N_SRC > 1) ? $clog2(N_SRC) : 0;
    localparam int LEAVES = 1 << LVL;
    localparam int NODES  = 2 * LEAVES - 1;

    // Heap-ordered node storage: node k has children 2k+1 (lower IDs) and 2k+2
    logic [NODES-1:0]  node_vld;
    logic [PRIO_W-1:0] node_prio [NODES];
    logic [ID_W-1:0]   node_id   [NODES];

    genvar gi;
    generate
        for (gi = 0; gi < LEAVES; gi++) begin : g_leaf
            if (gi < N_SRC) begin : g_real
                assign node_vld[LEAVES-1+gi]  = part_i[gi];
                assign node_prio[LEAVES-1+gi] = prio_i[gi*PRIO_W +: PRIO_W];
                assign node_id[LEAVES-1+gi]   = ID_W'(gi);
            end else begin : g_pad
                assign node_vld[LEAVES-1+gi]  = 1'b0;
                assign node_prio[LEAVES-1+gi] = '0;
                assign node_id[LEAVES-1+gi]   = '0;
            end
        end

        for (gi = 0; gi < LEAVES - 1; gi++) begin : g_node
            logic take_hi;
            // Right child wins only with strictly higher priority
            assign take_hi = node_vld[2*gi+2] &&
                             (!node_vld[2*gi+1] ||
                              (node_prio[2*gi+2] > node_prio[2*gi+1]));
            assign node_vld[gi]  = node_vld[2*gi+1] | node_vld[2*gi+2];
            assign node_prio[gi] = take_hi ? node_prio[2*gi+2] : node_prio[2*gi+1];
            assign node_id[gi]   = take_hi ? node_id[2*gi+2]   : node_id[2*gi+1];
        end
    endgenerate

    assign win_vld_o  = node_vld[0];
    assign win_prio_o = node_vld[0] ? node_prio[0] : '0;
    assign win_id_o   = node_vld[0] ? node_id[0]   : '0;

endmodule

// File: rtl/prio_sel_target.sv
// Selection and output registers for one target.
module prio_sel_target #(
    parameter int N_SRC  = 8,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 3
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [N_SRC-1:0]        pend_i,
    input  logic [N_SRC-1:0]        en_i,
    input  logic [N_SRC*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]       thr_i,
    output logic                    irq_o,
    output logic [ID_W-1:0]         id_o
);

    typedef struct packed {
        logic            irq;
        logic [ID_W-1:0] id;
    } tgt_state_t;

    tgt_state_t        st_d, st_q;
    logic [N_SRC-1:0]  part;
    logic              win_vld;
    logic [PRIO_W-1:0] win_prio;
    logic [ID_W-1:0]   win_id;

    assign part = pend_i & en_i;

    prio_sel_tree #(
        .N_SRC  (N_SRC),
        .PRIO_W (PRIO_W),
        .ID_W   (ID_W)
    ) u_tree (
        .part_i     (part),
        .prio_i     (prio_i),
        .win_vld_o  (win_vld),
        .win_prio_o (win_prio),
        .win_id_o   (win_id)
    );

    always_comb begin
        st_d     = st_q;
        st_d.id  = win_id;
        // Strict comparison: a priority-0 winner can never fire
        st_d.irq = win_vld && (win_prio > thr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;
    assign id_o  = st_q.id;

endmodule

// File: rtl/prio_irq_sel.sv
// Top: one selector per target over a shared pending vector.
module prio_irq_sel
    import prio_sel_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int N_TGT  = 2,
    parameter int PRIO_W = PRIO_W_DEF,
    parameter int ID_W   = id_width(N_SRC)
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [N_SRC-1:0]        pend_i,
    input  logic [N_TGT*N_SRC-1:0]  en_i,
    input  logic [N_SRC*PRIO_W-1:0] prio_i,
    input  logic [N_TGT*PRIO_W-1:0] thresh_i,
    output logic [N_TGT-1:0]        irq_o,
    output logic [N_TGT*ID_W-1:0]   id_o
);

    genvar gt;
    generate
        for (gt = 0; gt < N_TGT; gt++) begin : g_tgt
            prio_sel_target #(
                .N_SRC  (N_SRC),
                .PRIO_W (PRIO_W),
                .ID_W   (ID_W)
            ) u_sel (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .pend_i (pend_i),
                .en_i   (en_i[gt*N_SRC +: N_SRC]),
                .prio_i (prio_i),
                .thr_i  (thresh_i[gt*PRIO_W +: PRIO_W]),
                .irq_o  (irq_o[gt]),
                .id_o   (id_o[gt*ID_W +: ID_W])
            );
        end
    endgenerate

endmodule

// File: rtl/prio_irq_sel_chk.sv
// Property checker, bound to the top module.
module prio_irq_sel_chk #(
    parameter int N_SRC  = 8,
    parameter int N_TGT  = 2,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 3
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic [N_SRC-1:0]        pend_i,
    input logic [N_TGT*N_SRC-1:0]  en_i,
    input logic [N_SRC*PRIO_W-1:0] prio_i,
    input logic [N_TGT*PRIO_W-1:0] thresh_i,
    input logic [N_TGT-1:0]        irq_o,
    input logic [N_TGT*ID_W-1:0]   id_o
);

    logic                    prev_ok;
    logic [N_SRC-1:0]        prev_pend;
    logic [N_TGT*N_SRC-1:0]  prev_en;
    logic [N_SRC*PRIO_W-1:0] prev_prio;
    logic [N_TGT*PRIO_W-1:0] prev_thr;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_ok   <= 1'b0;
            prev_pend <= '0;
            prev_en   <= '0;
            prev_prio <= '0;
            prev_thr  <= '0;
        end else begin
            prev_ok   <= 1'b1;
            prev_pend <= pend_i;
            prev_en   <= en_i;
            prev_prio <= prio_i;
            prev_thr  <= thresh_i;
        end
    end

    // R9: outputs are cleared while reset is held
    p_reset_clear_r9: assert property (@(posedge clk_i)
        !rst_ni |-> (irq_o == '0) && (id_o == '0));

    genvar gt;
    generate
        for (gt = 0; gt < N_TGT; gt++) begin : g_chk
            logic [ID_W-1:0]   cur_id;
            logic [PRIO_W-1:0] cur_thr;
            logic [PRIO_W-1:0] win_pr;
            logic              win_part;
            logic              any_part;
            logic              higher;
            logic              tie_lower;

            assign cur_id  = id_o[gt*ID_W +: ID_W];
            assign cur_thr = prev_thr[gt*PRIO_W +: PRIO_W];

            always_comb begin
                win_pr    = '0;
                win_part  = 1'b0;
                any_part  = 1'b0;
                higher    = 1'b0;
                tie_lower = 1'b0;
                for (int s = 0; s < N_SRC; s++) begin
                    if (ID_W'(s) == cur_id) begin
                        win_pr   = prev_prio[s*PRIO_W +: PRIO_W];
                        win_part = prev_pend[s] & prev_en[gt*N_SRC+s];
                    end
                end
                for (int s = 0; s < N_SRC; s++) begin
                    if (prev_pend[s] && prev_en[gt*N_SRC+s]) begin
                        any_part = 1'b1;
                        if (prev_prio[s*PRIO_W +: PRIO_W] > win_pr)
                            higher = 1'b1;
                        if ((prev_prio[s*PRIO_W +: PRIO_W] == win_pr) &&
                            (ID_W'(s) < cur_id))
                            tie_lower = 1'b1;
                    end
                end
            end

            // R4, R1: a request implies a participating winner above threshold
            p_irq_strict_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                prev_ok && irq_o[gt] |-> win_part && (win_pr > cur_thr));

            // R8: priority 0 never raises a request
            p_prio_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                prev_ok && irq_o[gt] |-> (win_pr != '0));

            // R2: nobody participating outranks the reported winner
            p_top_prio_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
                prev_ok && any_part |-> win_part && !higher);

            // R3: no equal-priority participant has a smaller number
            p_tie_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
                prev_ok && any_part |-> !tie_lower);

            // R7: no participant gives ID 0 and no request on the next edge
            p_none_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                !(|(pend_i & en_i[gt*N_SRC +: N_SRC])) |=>
                    (id_o[gt*ID_W +: ID_W] == '0) && !irq_o[gt]);

            // R6: a nonzero ID change with the request low means a sub-threshold winner
            p_id_change_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
                prev_ok && !$stable(cur_id) && (cur_id != '0) |->
                    irq_o[gt] || (win_pr <= cur_thr));
        end
    endgenerate

endmodule

bind prio_irq_sel prio_irq_sel_chk #(
    .N_SRC  (N_SRC),
    .N_TGT  (N_TGT),
    .PRIO_W (PRIO_W),
    .ID_W   (ID_W)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pend_i   (pend_i),
    .en_i     (en_i),
    .prio_i   (prio_i),
    .thresh_i (thresh_i),
    .irq_o    (irq_o),
    .id_o     (id_o)
);

// File: tb/prio_irq_sel_tb.sv
module prio_irq_sel_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_SRC  = 8;
    localparam int N_TGT  = 2;
    localparam int PRIO_W = 3;
    localparam int ID_W   = 3;
    localparam int NVEC   = 8;
    localparam int WDOG   = 5000;

    typedef struct packed {
        logic [7:0]  pend;
        logic [15:0] en;    // {tgt1, tgt0}
        logic [23:0] prio;  // {p7 .. p0}
        logic [5:0]  thr;   // {tgt1, tgt0}
        logic [1:0]  irq;   // {tgt1, tgt0}
        logic [5:0]  id;    // {tgt1, tgt0}
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        // 0: nothing pending (R7)
        '{8'h00, 16'hFFFF, {8{3'd7}}, {3'd0,3'd0}, 2'b00, {3'd0,3'd0}},
        // 1: src4 prio5; thr 2 fires, thr 5 equal does not (R4, R6)
        '{8'h10, 16'hFFFF, {3'd1,3'd1,3'd1,3'd5,3'd1,3'd1,3'd1,3'd1},
          {3'd5,3'd2}, 2'b01, {3'd4,3'd4}},
        // 2: split masks, ties at top (R3, R10)
        '{8'hFF, {8'hF0,8'h0F}, {3'd7,3'd4,3'd7,3'd2,3'd6,3'd3,3'd6,3'd1},
          {3'd6,3'd0}, 2'b11, {3'd5,3'd1}},
        // 3: priority-0 winners, threshold 0 (R8)
        '{8'h81, {8'h80,8'h01}, {3'd0,3'd7,3'd7,3'd7,3'd7,3'd7,3'd7,3'd0},
          {3'd0,3'd0}, 2'b00, {3'd7,3'd0}},
        // 4: higher src7 disabled on tgt0 (R1)
        '{8'hC0, {8'hFF,8'h40}, {3'd7,3'd3,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0},
          {3'd7,3'd2}, 2'b01, {3'd7,3'd6}},
        // 5: all equal on tgt0, tgt1 masked off (R3, R7)
        '{8'hFF, {8'h00,8'hFF}, {8{3'd4}}, {3'd0,3'd3}, 2'b01, {3'd0,3'd0}},
        // 6: src5 outranks src2 (R2)
        '{8'h24, 16'hFFFF, {3'd0,3'd0,3'd6,3'd0,3'd0,3'd2,3'd0,3'd0},
          {3'd6,3'd5}, 2'b01, {3'd5,3'd5}},
        // 7: single prio-1 source, thr 0 vs 1 (R4)
        '{8'h08, 16'hFFFF, {3'd0,3'd0,3'd0,3'd0,3'd1,3'd0,3'd0,3'd0},
          {3'd1,3'd0}, 2'b01, {3'd3,3'd3}}
    };

    logic                    clk;
    logic                    rst_n;
    logic [N_SRC-1:0]        pend;
    logic [N_TGT*N_SRC-1:0]  en;
    logic [N_SRC*PRIO_W-1:0] prio;
    logic [N_TGT*PRIO_W-1:0] thr;
    logic [N_TGT-1:0]        irq;
    logic [N_TGT*ID_W-1:0]   id;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    prio_irq_sel #(
        .N_SRC  (N_SRC),
        .N_TGT  (N_TGT),
        .PRIO_W (PRIO_W),
        .ID_W   (ID_W)
    ) u_dut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .pend_i   (pend),
        .en_i     (en),
        .prio_i   (prio),
        .thresh_i (thr),
        .irq_o    (irq),
        .id_o     (id)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R7";
            1: return "R4/R6";
            2: return "R3/R10";
            3: return "R8";
            4: return "R1";
            5: return "R3/R7";
            6: return "R2";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string tag, input logic [1:0] exp_irq,
                         input logic [5:0] exp_id);
        n_chk++;
        if (irq !== exp_irq || id !== exp_id) begin
            n_fail++;
            $display("FAIL %s: irq=%b id=%h expected irq=%b id=%h",
                     tag, irq, id, exp_irq, exp_id);
        end
    endtask

    task automatic apply(input vec_t v);
        pend = v.pend;
        en   = v.en;
        prio = v.prio;
        thr  = v.thr;
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WDOG) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WDOG);
                report();
            end
        end
    end

    initial begin
        rst_n = 1'b0;
        pend  = '0;
        en    = '0;
        prio  = '0;
        thr   = '0;
        repeat (2) @(negedge clk);
        // R9: reset state
        check("R9 reset", 2'b00, 6'h00);
        rst_n = 1'b1;

        // Table walk: drive at falling edge, check at next falling edge
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i]);
            @(negedge clk);
            check(vec_tag(i), VECS[i].irq, VECS[i].id);
        end

        // R5: new inputs do not reach outputs before the edge
        apply(VECS[1]);
        #1;
        check("R5 hold", VECS[7].irq, VECS[7].id);
        @(negedge clk);
        check("R5 update", VECS[1].irq, VECS[1].id);

        // R9: asynchronous clear mid-cycle
        apply(VECS[2]);
        @(negedge clk);
        check("R10 both fire", 2'b11, {3'd5, 3'd1});
        #(CLK_PERIOD/4);
        rst_n = 1'b0;
        #1;
        check("R9 async", 2'b00, 6'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R5 after reset", 2'b11, {3'd5, 3'd1});

        report();
    end

endmodule